// File: doc/BRIEF.md
# Indexed RTC Register Port with Interrupt Flags

This block is the host-facing register front end of a real-time clock. A host reaches a 128-location byte file through two addresses: writing the even address selects a location, and reading or writing the odd address touches the location selected. Most locations are plain storage. Four are special: a control byte with a read-only top bit, a mode byte that holds the interrupt enables, a flag byte that collects events, and a constant status byte.

Event pulses from the time base and the alarm comparator (periodic, alarm, update-ended) are merged into the flag byte. When a newly raised flag meets its enable, a summary bit and the level interrupt output rise. Reading the flag byte hands its value to the host and clears it in the same cycle. An event in that same cycle is kept. Enabling an interrupt whose flag is already pending raises the interrupt straight away. A synchronous soft reset input drops the pending state and some enables.

Read data leaves on a valid-only stream. `bus_rvalid` is high for exactly one cycle, the cycle after a read strobe, and `bus_rdata` holds the byte in that cycle. There is no back-pressure: the host must take the byte when it is offered. Writes complete in the cycle they are strobed. A cycle with both strobes high is a write, and the read is dropped.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even address (`bus_addr`=0) loads `bus_wdata[6:0]` into the index. A read of the even address returns `{1'b0, index}`. Data accesses at the odd address leave the index unchanged, so there is no auto-increment.
- R2: For a read strobe (`bus_rd`=1, `bus_wr`=0), `bus_rvalid` is high in the next cycle, and only then, together with the addressed byte. A byte written at the odd address to any index other than 0x0A–0x0D reads back unchanged.
- R3: After `rst_n` the index is 0x00, the control byte (index 0x0A) reads 0x26, the mode byte (0x0B) 0x02, the flag byte (0x0C) 0x00 and the status byte (0x0D) 0x80. `irq` and `bus_rvalid` are low.
- R4: Bit 7 of the control byte is read-only and reads 0. Bits 6:0 keep what is written.
- R5: An event pulse sets its flag bit whether or not it is enabled. The periodic event sets bit 6, the alarm event bit 5 and the update-ended event bit 4. Flag bits 3:0 read 0.
- R6: Flag bit 7 and `irq` rise one cycle after an event newly sets a flag whose enable is set. The enables are mode bits 6 (periodic), 5 (alarm) and 4 (update-ended). Events that are not enabled leave `irq` low.
- R7: A read of the flag byte returns its prior value, then clears the byte and drops `irq`. An event arriving in the same cycle is kept, and it is judged against the enables as a new flag.
- R8: A write to the mode byte raises bit 7 and `irq` if a written enable meets a pending flag. Otherwise it clears bit 7 and `irq`. The pending flags are not changed.
- R9: Writes to the flag byte and the status byte have no effect.
- R10: A `soft_rst` pulse clears mode bits 6, 5 and 3 and keeps the other mode bits. It also clears all flag bits and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to power-up values |
| soft_rst | input | 1 | Synchronous reset of enables, flags and interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, ignored while `bus_wr` is high |
| bus_addr | input | 1 | 0 selects the index, 1 selects the indexed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | One-cycle read data valid |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Registered level interrupt request |

## Verification
The byte file is swept over all 128 indices with an arithmetic pattern. This separates a wrong or skipped address from a dead or shadowed location. The interrupt path is tried with every enable mask against every combination of event pulses. Each result is compared with the AND-reduction of the two masks, which tells apart a missing enable, a crossed bit position and a flag that should be set but is not. A second sweep first sets flags with the enables off and then writes each enable mask. This shows whether a mode write raises `irq` for pending flags and lowers it again. The remaining directed cases cover a flag read that coincides with an event, the soft reset masks, and the bytes that ignore writes.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Positions inside the flag byte and the mode byte.
  localparam int SUM_BIT  = 7;
  localparam int PER_BIT  = 6;
  localparam int ALM_BIT  = 5;
  localparam int UPD_BIT  = 4;
  localparam int SQW_BIT  = 3;
  localparam int EVT_N    = 3;
  localparam int EVT_LO   = UPD_BIT;
  localparam int EVT_HI   = PER_BIT;

  // Event vector ordering: [2] periodic, [1] alarm, [0] update-ended.
  typedef logic [EVT_N-1:0] evt_vec_t;

  typedef enum logic [1:0] {
    SEL_RAM  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_MODE = 2'd2,
    SEL_FLAG = 2'd3
  } sel_e;
endpackage

// File: rtl/rtcp_index_reg.sv
module rtcp_index_reg #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= din;
  end
endmodule

// File: rtl/rtcp_store.sv
module rtcp_store #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtcp_ctrl_regs.sv
module rtcp_ctrl_regs
  import rtcp_pkg::*;
#(
  parameter byte_t CTRL_RST   = 8'h26,
  parameter byte_t CTRL_RO    = 8'h80,
  parameter byte_t MODE_RST   = 8'h02,
  parameter byte_t MODE_SCLR  = 8'h68
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  ctrl_we,
  input  logic  mode_we,
  input  byte_t wdata,
  output byte_t ctrl_q,
  output byte_t mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST & ~CTRL_RO;
    end else if (ctrl_we) begin
      ctrl_q <= (wdata & ~CTRL_RO) | (ctrl_q & CTRL_RO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_RST;
    else if (soft_rst) mode_q <= mode_q & ~MODE_SCLR;
    else if (mode_we)  mode_q <= wdata;
  end
endmodule

// File: rtl/rtcp_flag_unit.sv
module rtcp_flag_unit
  import rtcp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  evt_vec_t evt,
  input  evt_vec_t enables,
  input  logic     rd_clear,
  input  logic     mode_we,
  input  evt_vec_t mode_wen,
  output byte_t    flags,
  output logic     irq
);
  evt_vec_t src_q, base, src_n, newly;
  logic     sum_q, base_sum, sum_n;

  always_comb begin
    base     = rd_clear ? '0 : src_q;
    base_sum = rd_clear ? 1'b0 : sum_q;
    src_n    = base | evt;
    newly    = evt & ~base;
    if (mode_we) sum_n = |(mode_wen & src_n);
    else         sum_n = base_sum | (|(newly & enables));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      sum_q <= 1'b0;
    end else if (soft_rst) begin
      src_q <= '0;
      sum_q <= 1'b0;
    end else begin
      src_q <= src_n;
      sum_q <= sum_n;
    end
  end

  always_comb begin
    flags                 = '0;
    flags[SUM_BIT]        = sum_q;
    flags[EVT_HI:EVT_LO]  = src_q;
  end

  assign irq = sum_q;
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtcp_pkg::*;
#(
  parameter int          IDX_W     = 7,
  parameter logic [6:0]  CTRL_IDX  = 7'h0A,
  parameter logic [6:0]  MODE_IDX  = 7'h0B,
  parameter logic [6:0]  FLAG_IDX  = 7'h0C,
  parameter logic [6:0]  STAT_IDX  = 7'h0D,
  parameter byte_t       STAT_VAL  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_rvalid,
  input  logic        evt_periodic,
  input  logic        evt_alarm,
  input  logic        evt_update,
  output logic        irq
);
  localparam int PAD_W = BYTE_W - IDX_W;

  logic [IDX_W-1:0] idx_q;
  byte_t ctrl_q, mode_q, flag_q, ram_q, rd_mux;
  logic  wr_idx, wr_dat, rd_any, rd_dat;
  logic  is_ctrl, is_mode, is_flag, is_stat;
  sel_e  sel;

  // Host strobe decode: a write takes the cycle, a read then drops.
  assign wr_idx = bus_wr & ~bus_addr;
  assign wr_dat = bus_wr &  bus_addr;
  assign rd_any = bus_rd & ~bus_wr;
  assign rd_dat = rd_any &  bus_addr;

  assign is_ctrl = (idx_q == CTRL_IDX[IDX_W-1:0]);
  assign is_mode = (idx_q == MODE_IDX[IDX_W-1:0]);
  assign is_flag = (idx_q == FLAG_IDX[IDX_W-1:0]);
  assign is_stat = (idx_q == STAT_IDX[IDX_W-1:0]);

  always_comb begin
    if (is_ctrl)      sel = SEL_CTRL;
    else if (is_mode) sel = SEL_MODE;
    else if (is_flag) sel = SEL_FLAG;
    else              sel = SEL_RAM;
  end

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[BYTE_W-1:IDX_W];

  rtcp_index_reg #(.IDX_W(IDX_W)) u_index (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_idx),
    .din  (bus_wdata[IDX_W-1:0]),
    .idx  (idx_q)
  );

  rtcp_store #(.IDX_W(IDX_W), .DATA_W(BYTE_W)) u_store (
    .clk  (clk),
    .we   (wr_dat & (sel == SEL_RAM) & ~is_stat),
    .addr (idx_q),
    .wdata(bus_wdata),
    .rdata(ram_q)
  );

  rtcp_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .ctrl_we (wr_dat & is_ctrl),
    .mode_we (wr_dat & is_mode),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q)
  );

  rtcp_flag_unit u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .evt     ({evt_periodic, evt_alarm, evt_update}),
    .enables (mode_q[EVT_HI:EVT_LO]),
    .rd_clear(rd_dat & is_flag),
    .mode_we (wr_dat & is_mode),
    .mode_wen(bus_wdata[EVT_HI:EVT_LO]),
    .flags   (flag_q),
    .irq     (irq)
  );

  always_comb begin
    if (!bus_addr) begin
      rd_mux = {{PAD_W{1'b0}}, idx_q};
    end else if (is_stat) begin
      rd_mux = STAT_VAL;
    end else begin
      unique case (sel)
        SEL_CTRL: rd_mux = ctrl_q;
        SEL_MODE: rd_mux = mode_q;
        SEL_FLAG: rd_mux = flag_q;
        default:  rd_mux = ram_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_any;
      if (rd_any) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker #(
  parameter int         IDX_W    = 7,
  parameter logic [6:0] MODE_IDX = 7'h0B,
  parameter logic [6:0] FLAG_IDX = 7'h0C,
  parameter logic [6:0] STAT_IDX = 7'h0D
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             bus_rvalid,
  input logic             evt_periodic,
  input logic             evt_alarm,
  input logic             evt_update,
  input logic             irq,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       mode
);
  logic rd_ok, any_evt, at_flag, at_mode, at_stat;
  assign rd_ok   = bus_rd & ~bus_wr;
  assign any_evt = evt_periodic | evt_alarm | evt_update;
  assign at_flag = (idx == FLAG_IDX[IDX_W-1:0]);
  assign at_mode = (idx == MODE_IDX[IDX_W-1:0]);
  assign at_stat = (idx == STAT_IDX[IDX_W-1:0]);

  assert_index_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> $stable(idx));

  assert_rvalid_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> bus_rvalid);

  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !bus_rvalid);

  assert_enabled_alarm_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_alarm && mode[5] && !soft_rst && !(bus_wr && bus_addr && at_mode)) |=> irq);

  assert_flag_read_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && bus_addr && at_flag && !any_evt && !soft_rst) |=> !irq);

  assert_status_constant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && bus_addr && at_stat) |=> (bus_rdata == 8'h80));

  assert_flag_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && at_flag && !any_evt && !soft_rst) |=> $stable(irq));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && ((mode & 8'h68) == 8'h00)));
endmodule

bind rtc_index_port rtcp_checker #(
  .IDX_W   (IDX_W),
  .MODE_IDX(MODE_IDX),
  .FLAG_IDX(FLAG_IDX),
  .STAT_IDX(STAT_IDX)
) u_rtcp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .evt_periodic(evt_periodic),
  .evt_alarm   (evt_alarm),
  .evt_update  (evt_update),
  .irq         (irq),
  .idx         (idx_q),
  .mode        (mode_q)
);

// File: tb/tb_rtc_index_port.sv
`timescale 1ns/1ps
module tb_rtc_index_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       evt_periodic = 1'b0;
  logic       evt_alarm = 1'b0;
  logic       evt_update = 1'b0;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] rd_val;

  always #2 clk = ~clk;

  rtc_index_port dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic host_wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R2 rvalid after read", {7'd0, bus_rvalid}, 8'h01);
  endtask

  task automatic reg_rd(input logic [6:0] i, output logic [7:0] d);
    host_wr(1'b0, {1'b0, i});
    host_rd(1'b1, d);
  endtask

  task automatic reg_wr(input logic [6:0] i, input logic [7:0] d);
    host_wr(1'b0, {1'b0, i});
    host_wr(1'b1, d);
  endtask

  task automatic pulse(input logic [2:0] ev);
    {evt_periodic, evt_alarm, evt_update} = ev;
    @(negedge clk);
    {evt_periodic, evt_alarm, evt_update} = 3'b000;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 59) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..none actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: power-up values
    chk("R3 irq low", {7'd0, irq}, 8'h00);
    chk("R3 rvalid low", {7'd0, bus_rvalid}, 8'h00);
    host_rd(1'b0, rd_val); chk("R3 index reset", rd_val, 8'h00);
    @(negedge clk);
    chk("R2 rvalid single cycle", {7'd0, bus_rvalid}, 8'h00);
    reg_rd(7'h0A, rd_val); chk("R3 control reset", rd_val, 8'h26);
    reg_rd(7'h0B, rd_val); chk("R3 mode reset", rd_val, 8'h02);
    reg_rd(7'h0C, rd_val); chk("R3 flag reset", rd_val, 8'h00);
    reg_rd(7'h0D, rd_val); chk("R3 status reset", rd_val, 8'h80);

    // R1: index from bits 6:0, kept across data accesses
    host_wr(1'b0, 8'hD5);
    host_rd(1'b0, rd_val); chk("R1 index load", rd_val, 8'h55);
    host_wr(1'b1, 8'h3C);
    host_rd(1'b1, rd_val); chk("R1 data at index", rd_val, 8'h3C);
    host_rd(1'b0, rd_val); chk("R1 index kept", rd_val, 8'h55);

    // R2: sweep every plain location
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) reg_wr(7'(i), pat(i));
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) begin
        reg_rd(7'(i), rd_val);
        chk($sformatf("R2 storage idx=%0d", i), rd_val, pat(i));
      end

    // R4: control bit 7 read-only
    reg_wr(7'h0A, 8'hFF);
    reg_rd(7'h0A, rd_val); chk("R4 control ro bit", rd_val, 8'h7F);
    reg_wr(7'h0A, 8'h26);
    reg_rd(7'h0A, rd_val); chk("R4 control write", rd_val, 8'h26);

    // R9: flag and status ignore writes
    reg_wr(7'h0C, 8'hFF);
    chk("R9 flag write no irq", {7'd0, irq}, 8'h00);
    reg_rd(7'h0C, rd_val); chk("R9 flag write ignored", rd_val, 8'h00);
    reg_wr(7'h0D, 8'h00);
    reg_rd(7'h0D, rd_val); chk("R9 status write ignored", rd_val, 8'h80);

    // R5, R6, R7: every enable mask against every event set
    for (int en = 0; en < 8; en++)
      for (int ev = 0; ev < 8; ev++) begin
        logic hit;
        hit = |(3'(en) & 3'(ev));
        reg_wr(7'h0B, {1'b0, 3'(en), 4'h2});
        host_wr(1'b0, 8'h0C);
        pulse(3'(ev));
        chk($sformatf("R6 irq en=%0d ev=%0d", en, ev), {7'd0, irq}, {7'd0, hit});
        host_rd(1'b1, rd_val);
        chk($sformatf("R5 flags en=%0d ev=%0d", en, ev), rd_val, {hit, 3'(ev), 4'h0});
        chk($sformatf("R7 irq cleared en=%0d ev=%0d", en, ev), {7'd0, irq}, 8'h00);
      end

    // R8: pending flags met by a later enable write
    for (int f = 1; f < 8; f++)
      for (int e = 0; e < 8; e++) begin
        logic hit;
        hit = |(3'(f) & 3'(e));
        reg_wr(7'h0B, 8'h02);
        pulse(3'(f));
        chk($sformatf("R6 disabled f=%0d", f), {7'd0, irq}, 8'h00);
        host_wr(1'b1, {1'b0, 3'(e), 4'h2});
        chk($sformatf("R8 enable f=%0d e=%0d", f, e), {7'd0, irq}, {7'd0, hit});
        host_wr(1'b1, 8'h02);
        chk($sformatf("R8 disable f=%0d e=%0d", f, e), {7'd0, irq}, 8'h00);
        reg_rd(7'h0C, rd_val);
        chk($sformatf("R8 flags kept f=%0d e=%0d", f, e), rd_val, {1'b0, 3'(f), 4'h0});
      end

    // R7: flag read in the same cycle as a new event
    reg_wr(7'h0B, 8'h62);
    host_wr(1'b0, 8'h0C);
    pulse(3'b010);
    chk("R7 alarm irq", {7'd0, irq}, 8'h01);
    bus_rd = 1'b1; bus_addr = 1'b1; evt_periodic = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; evt_periodic = 1'b0;
    chk("R7 read value before clear", bus_rdata, 8'hA0);
    chk("R7 same-cycle event irq", {7'd0, irq}, 8'h01);
    host_rd(1'b1, rd_val); chk("R7 same-cycle event kept", rd_val, 8'hC0);
    chk("R7 irq after second read", {7'd0, irq}, 8'h00);

    // R10: soft reset
    reg_wr(7'h0B, 8'h7A);
    pulse(3'b001);
    chk("R10 irq before soft reset", {7'd0, irq}, 8'h01);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R10 irq dropped", {7'd0, irq}, 8'h00);
    reg_rd(7'h0B, rd_val); chk("R10 mode masked", rd_val, 8'h12);
    reg_rd(7'h0C, rd_val); chk("R10 flags cleared", rd_val, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule